// File: doc/BRIEF.md
# SECDED Error-Correcting Word Memory with Shutdown Escalation

This block is a single-port word memory whose stored words are protected by a single-error-correct, double-error-detect code. Each write stores the data word together with check bits computed from it. Each read checks the stored word on its way out, repairs any single flipped bit and returns the repaired data. A read that finds an error of either kind also raises a one-cycle error event, which carries the failing address and a two-bit error class so that an external logger can record it.

An uncorrectable error also drives an emergency-shutdown request. That request stays latched until reset, so the system cannot go on running on corrupted contents. A test input is XORed into the check bits while a word is written. This lets verification place exactly the fault patterns it needs into memory without reaching into the array.

Top module: `ecc_guard_ram`

## Requirements
- R1: After reset, `rd_valid`, `evt_valid` and `halt_req` are low.
- R2: A read request (`req`=1, `we`=0) of a word written with `inj_flip`=0 returns the written data on `rd_data` with `rd_valid`=1 one clock later, and `evt_class`=00 with `evt_valid` low.
- R3: The stored check field is 7 bits. Codeword positions 1..38 hold the data, and check bit i (i=0..5) sits at position 2^i. The 32 data bits fill the other positions in ascending order, with data bit 0 at position 3. Check bit i is the XOR of all data positions whose index has bit i set. Bit 6 is chosen so that the parity over all 39 bits is even. The stored check field is this code XOR `inj_flip`.
- R4: A stored word with exactly one wrong data bit reads back with that bit corrected and `evt_class`=01.
- R5: A stored word with exactly one wrong check bit, including bit 6, reads back with unchanged data and `evt_class`=01.
- R6: A stored word with two wrong bits reads back with `evt_class`=10, and `evt_valid` is a pulse of exactly one cycle.
- R7: During an error event, `evt_addr` equals the address of the read that produced it.
- R8: `halt_req` is high in the same cycle as an uncorrectable event and stays high until reset. Correctable events never raise it.
- R9: A write cycle produces neither `rd_valid` nor `evt_valid` on the next cycle.
- R10: Reset clears a latched `halt_req`.
- R11: An odd-parity syndrome that points beyond codeword position 38 is classed uncorrectable (10).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Access request |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W | Word address |
| wr_data | input | DATA_W | Write data |
| inj_flip | input | 7 | Pattern XORed into stored check bits on write |
| rd_data | output | DATA_W | Corrected read data |
| rd_valid | output | 1 | Read data valid, one cycle after the request |
| evt_valid | output | 1 | One-cycle error event |
| evt_class | output | 2 | 00 none, 01 corrected, 10 uncorrectable |
| evt_addr | output | ADDR_W | Address of the read that produced the event |
| halt_req | output | 1 | Latched emergency-shutdown request |

## Verification
The bench builds the block with DATA_W=32 and ADDR_W=4. With 32 data bits the code has six Hamming bits, so syndromes can reach 63, and the out-of-range case above position 38 can be reached with a single injected pattern. With sixteen words, both the lowest and the highest address can be written and then reported through `evt_addr`. Data-bit faults are built by writing a flipped word and injecting the difference between the check bits of the intended word and those of the flipped word.

// File: rtl/ecc_guard_ram.sv
module ecc_guard_ram #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [6:0]        inj_flip,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              evt_valid,
  output logic [1:0]        evt_class,
  output logic [ADDR_W-1:0] evt_addr,
  output logic              halt_req
);
  function automatic int ham_count(input int dw);
    for (int p = 1; p < 16; p++)
      if ((1 << p) >= dw + p + 1) return p;
    return 16;
  endfunction

  localparam int HAM_W = ham_count(DATA_W);
  localparam int CHK_W = HAM_W + 1;
  localparam int CW_N  = DATA_W + HAM_W;
  localparam int DEPTH = 1 << ADDR_W;
  localparam int WORD_W = DATA_W + CHK_W;

  localparam logic [1:0] CLS_NONE = 2'b00;
  localparam logic [1:0] CLS_COR  = 2'b01;
  localparam logic [1:0] CLS_UNC  = 2'b10;

  function automatic logic [HAM_W-1:0] ham_of(input logic [DATA_W-1:0] d);
    logic [HAM_W-1:0] h;
    int k;
    h = '0;
    k = 0;
    for (int pos = 1; pos <= CW_N; pos++) begin
      if ((pos & (pos - 1)) != 0) begin
        if (d[k]) h = h ^ pos[HAM_W-1:0];
        k++;
      end
    end
    return h;
  endfunction

  function automatic logic [DATA_W-1:0] fix_mask(input logic [HAM_W-1:0] s);
    logic [DATA_W-1:0] m;
    int k;
    m = '0;
    k = 0;
    for (int pos = 1; pos <= CW_N; pos++) begin
      if ((pos & (pos - 1)) != 0) begin
        if (pos == int'(s)) m[k] = 1'b1;
        k++;
      end
    end
    return m;
  endfunction

  logic [WORD_W-1:0] mem [DEPTH];
  logic [WORD_W-1:0] rd_word_q;
  logic [ADDR_W-1:0] rd_addr_q;
  logic              rd_valid_q;
  logic              halt_q;

  logic [HAM_W-1:0]  wr_ham;
  logic [CHK_W-1:0]  wr_chk;
  logic [DATA_W-1:0] st_data;
  logic [CHK_W-1:0]  st_chk;
  logic [HAM_W-1:0]  syn;
  logic              par_odd;
  logic [1:0]        cls;

  assign wr_ham = ham_of(wr_data);
  assign wr_chk = {(^wr_data) ^ (^wr_ham), wr_ham} ^ inj_flip;

  always_ff @(posedge clk) begin
    if (req && we) mem[addr] <= {wr_chk, wr_data};
    if (req && !we) rd_word_q <= mem[addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid_q <= 1'b0;
      rd_addr_q  <= '0;
    end else begin
      rd_valid_q <= req && !we;
      if (req && !we) rd_addr_q <= addr;
    end
  end

  assign st_data = rd_word_q[DATA_W-1:0];
  assign st_chk  = rd_word_q[WORD_W-1:DATA_W];
  assign syn     = ham_of(st_data) ^ st_chk[HAM_W-1:0];
  assign par_odd = (^st_data) ^ (^st_chk);

  always_comb begin
    if (!rd_valid_q) cls = CLS_NONE;
    else if (!par_odd && syn == '0) cls = CLS_NONE;
    else if (par_odd && int'(syn) <= CW_N) cls = CLS_COR;
    else cls = CLS_UNC;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) halt_q <= 1'b0;
    else if (cls == CLS_UNC) halt_q <= 1'b1;
  end

  assign rd_data   = (cls == CLS_COR) ? (st_data ^ fix_mask(syn)) : st_data;
  assign rd_valid  = rd_valid_q;
  assign evt_class = cls;
  assign evt_valid = cls != CLS_NONE;
  assign evt_addr  = rd_addr_q;
  assign halt_req  = halt_q || (cls == CLS_UNC);

  p_evt_class_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |-> (evt_class == CLS_COR || evt_class == CLS_UNC));
  p_evt_needs_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |-> rd_valid);
  p_read_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !we) |=> rd_valid);
  p_write_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req && we) |=> !rd_valid);
  p_evt_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !we) |=> (evt_addr == $past(addr)));
  p_unc_halts_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_class == CLS_UNC) |-> halt_req);
  p_halt_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    halt_req |=> halt_req);
endmodule

// File: tb/ecc_guard_ram_tb.sv
`timescale 1ns/1ps
module ecc_guard_ram_tb_top;
  localparam int DW = 32;
  localparam int AW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [6:0] inj_flip = '0;
  logic [DW-1:0] rd_data;
  logic rd_valid, evt_valid, halt_req;
  logic [1:0] evt_class;
  logic [AW-1:0] evt_addr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ecc_guard_ram #(.DATA_W(DW), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr),
    .wr_data(wr_data), .inj_flip(inj_flip), .rd_data(rd_data),
    .rd_valid(rd_valid), .evt_valid(evt_valid), .evt_class(evt_class),
    .evt_addr(evt_addr), .halt_req(halt_req));

  function automatic logic [6:0] code_of(input logic [DW-1:0] d);
    logic [38:1] cw;
    logic [6:0] c;
    int k = 0;
    cw = '0;
    for (int p = 1; p <= 38; p++)
      if (p != 1 && p != 2 && p != 4 && p != 8 && p != 16 && p != 32) begin
        cw[p] = d[k];
        k++;
      end
    c = '0;
    for (int i = 0; i < 6; i++)
      for (int p = 1; p <= 38; p++)
        if (((p >> i) & 1) == 1) c[i] = c[i] ^ cw[p];
    c[6] = (^d) ^ (^c[5:0]);
    return c;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [6:0] m);
    @(negedge clk);
    req = 1; we = 1; addr = a; wr_data = d; inj_flip = m;
    @(negedge clk);
    req = 0; we = 0; inj_flip = '0;
  endtask

  logic [DW-1:0] r_data;
  logic r_valid, r_evt, r_halt;
  logic [1:0] r_cls;
  logic [AW-1:0] r_addr;

  task automatic do_read(input logic [AW-1:0] a);
    @(negedge clk);
    req = 1; we = 0; addr = a;
    @(negedge clk);
    r_data = rd_data; r_valid = rd_valid; r_evt = evt_valid;
    r_cls = evt_class; r_addr = evt_addr; r_halt = halt_req;
    req = 0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(!rd_valid, "R1 rd_valid", rd_valid, 0);
    check(!evt_valid, "R1 evt_valid", evt_valid, 0);
    check(!halt_req, "R1 halt_req", halt_req, 0);
  endtask

  task automatic t_clean(input logic [AW-1:0] a, input logic [DW-1:0] d);
    do_write(a, d, 7'h00);
    check(!rd_valid && !evt_valid, "R9 write silent", {rd_valid, evt_valid}, 0);
    do_read(a);
    check(r_valid, "R2 rd_valid", r_valid, 1);
    check(r_data == d, "R2 data", r_data, d);
    check(r_cls == 2'b00 && !r_evt, "R2 no event", {r_evt, r_cls}, 0);
  endtask

  task automatic t_data_fix(input logic [AW-1:0] a, input logic [DW-1:0] d, input int bitn);
    logic [DW-1:0] bad;
    bad = d ^ (DW'(1) << bitn);
    do_write(a, bad, code_of(bad) ^ code_of(d));
    do_read(a);
    check(r_data == d, "R4 R3 corrected data", r_data, d);
    check(r_evt && r_cls == 2'b01, "R4 class", r_cls, 1);
    check(r_addr == a, "R7 addr", r_addr, a);
    check(!r_halt, "R8 no halt on correctable", r_halt, 0);
  endtask

  task automatic t_chk_fix(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [6:0] m);
    do_write(a, d, m);
    do_read(a);
    check(r_data == d, "R5 data", r_data, d);
    check(r_evt && r_cls == 2'b01, "R5 class", r_cls, 1);
    check(!r_halt, "R8 no halt", r_halt, 0);
  endtask

  task automatic t_double(input logic [AW-1:0] a, input logic [DW-1:0] d);
    do_write(a, d, 7'h03);
    do_read(a);
    check(r_evt && r_cls == 2'b10, "R6 class", r_cls, 2);
    check(r_addr == a, "R7 addr", r_addr, a);
    check(r_halt, "R8 halt same cycle", r_halt, 1);
    @(negedge clk);
    check(!evt_valid, "R6 one-cycle pulse", evt_valid, 0);
    check(halt_req, "R8 halt held", halt_req, 1);
  endtask

  task automatic t_out_of_range(input logic [AW-1:0] a);
    do_write(a, 32'h0F0F_1234, 7'h7F);
    do_read(a);
    check(r_evt && r_cls == 2'b10, "R11 class", r_cls, 2);
    do_read(4'h1);
    check(halt_req, "R8 halt after clean read", halt_req, 1);
  endtask

  task automatic t_reset_clears();
    @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(!halt_req, "R10 halt cleared", halt_req, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_clean(4'h0, 32'hDEAD_BEEF);
    t_clean(4'hF, 32'h0000_0001);
    t_clean(4'h1, 32'hFFFF_FFFF);
    t_data_fix(4'h2, 32'hA5A5_5A5A, 0);
    t_data_fix(4'hF, 32'h1357_9BDF, 31);
    t_chk_fix(4'h3, 32'hCAFE_F00D, 7'h04);
    t_chk_fix(4'h4, 32'h8000_0000, 7'h40);
    t_double(4'hF, 32'h2468_ACE0);
    t_out_of_range(4'h5);
    t_reset_clears();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule